// File: doc/BRIEF.md
# Two-Thread Decode Share and Congestion Throttle

This block sits beside the decode stage of a core that runs two hardware threads at once. Each cycle it names at most one thread that may use the decode slot. Over a repeating window of decode cycles, the slots are split between the threads according to a small priority number that software sets for each thread. The block also watches how much of the shared machinery each thread holds. It looks at two things per thread: the outstanding second-level load misses plus translation misses, and the number of reorder-buffer entries the thread occupies.

When a thread holds too much, the block throttles it in stages. First the thread's priority drops by one step. If the congestion lasts, decoding for that thread stops. If it lasts longer still, the block sends a single-cycle request to flush the thread's instructions that are waiting for dispatch, and decoding stays blocked after the flush. Congestion ends only when both measures fall a hysteresis margin below their trigger levels. At that point the throttle is released and the thread's own priority applies again. Only one thread can be under throttle at any time.

Top module: `smt_thr_throttle`

## Requirements
- R1: During reset and in the first cycle after it, no inhibit or flush output is high, and the decode window position is 0. With equal non-zero priorities, thread 0 therefore holds the slot in the first cycle after reset.
- R2: The window has WINDOW (8) cycles, and its position advances by one each cycle, wrapping from 7 to 0. For effective weights w0 and w1, thread 0 gets the positions below s0 and thread 1 gets the rest. Here s0 = floor(w0*WINDOW/(w0+w1)) when w1 is non-zero, s0 = WINDOW when w1 is 0, and no thread gets a slot when both weights are 0. The effective weight is the thread's priority unless a throttle stage changes it.
- R3: A thread whose effective weight is 0 receives no decode slot.
- R4: A thread is congested when its L2 miss count plus its TLB miss count is at least MISS_TH (8), or when its reorder-buffer count is at least ROB_TH (40). In the cycle after an unthrottled block sees congestion, that thread enters the lowered stage. In that stage its weight is its priority minus one when the priority is above 1, and unchanged otherwise.
- R5: After 8 cycles in the lowered stage, the thread's decode-inhibit output rises. While it is inhibited, its weight is 0.
- R6: After 32 cycles of inhibit, the thread's flush output is high for exactly one cycle. After that, the inhibit output stays high.
- R7: The throttle is released when the thread's miss sum is below MISS_TH-HYST (4) and its reorder-buffer count is below ROB_TH-HYST (36). The outputs return to normal in the next cycle. Values between the release level and the trigger level keep the throttle in its current stage.
- R8: At most one thread is throttled at a time. If both threads are congested in the cycle a throttle starts, the one with the larger reorder-buffer count is chosen; on a tie, thread 0 is chosen.
- R9: At most one thread receives the decode slot in any cycle, and an inhibited thread never receives it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prio_i | input | 2x3 | Software priority per thread |
| l2_miss_i | input | 2x5 | Outstanding L2 load misses per thread |
| tlb_miss_i | input | 2x5 | Outstanding TLB misses per thread |
| rob_used_i | input | 2x6 | Reorder-buffer entries held per thread |
| decode_grant_o | output | 2 | Decode slot owner this cycle, at most one bit set |
| decode_inhibit_o | output | 2 | Decode inhibit per thread |
| dispatch_flush_o | output | 2 | One-cycle request to flush a thread's waiting instructions |

## Verification
The two functions most likely to coincide are the release of a throttle and an escalation step: the falling congestion that releases a thread can arrive in the same cycle that its lowered stage turns into inhibit, or that inhibit turns into the flush pulse. The second coincidence is both threads becoming congested in the same cycle. Random stimulus holds each miss and occupancy value for a random stretch that spans the trigger and release levels, so both coincidences occur many times. Directed steps force them at fixed points. In every cycle the bench compares the grant, inhibit and flush outputs against its own model of the stages and the slot formula. When release and escalation coincide, the model expects the release to win: no inhibit and no flush appear in the next cycle.

// File: rtl/smt_thr_pkg.sv
package smt_thr_pkg;

    localparam int NTHR = 2;

    typedef enum logic [2:0] {
        TS_IDLE    = 3'd0,
        TS_LOWER   = 3'd1,
        TS_INHIBIT = 3'd2,
        TS_FLUSH   = 3'd3,
        TS_BLOCK   = 3'd4
    } thr_state_e;

    typedef struct packed {
        logic congested;
        logic cleared;
    } cong_flags_t;

    // Window positions below the returned value belong to thread 0.
    function automatic int unsigned first_share(input int unsigned w0,
                                                input int unsigned w1,
                                                input int unsigned window);
        if (w0 + w1 == 0) return 0;
        if (w1 == 0) return window;
        return (w0 * window) / (w0 + w1);
    endfunction

    // Weight after one step of demotion, never pushed to zero.
    function automatic int unsigned demote(input int unsigned p);
        return (p > 1) ? p - 1 : p;
    endfunction

endpackage

// File: rtl/smt_thr_cong_mon.sv
module smt_thr_cong_mon
    import smt_thr_pkg::*;
#(
    parameter int MISS_W  = 5,
    parameter int ROB_W   = 6,
    parameter int MISS_TH = 8,
    parameter int ROB_TH  = 40,
    parameter int HYST    = 4
) (
    input  logic [MISS_W-1:0] l2_miss,
    input  logic [MISS_W-1:0] tlb_miss,
    input  logic [ROB_W-1:0]  rob_used,
    output cong_flags_t       flags
);
    localparam int SUM_W = MISS_W + 1;
    localparam int RLS_W = ROB_W + 1;
    localparam logic [SUM_W-1:0] MISS_ON  = SUM_W'(MISS_TH);
    localparam logic [SUM_W-1:0] MISS_OFF = SUM_W'(MISS_TH - HYST);
    localparam logic [RLS_W-1:0] ROB_ON   = RLS_W'(ROB_TH);
    localparam logic [RLS_W-1:0] ROB_OFF  = RLS_W'(ROB_TH - HYST);

    logic [SUM_W-1:0] miss_sum;
    logic [RLS_W-1:0] rob_ext;

    always_comb begin
        miss_sum        = {1'b0, l2_miss} + {1'b0, tlb_miss};
        rob_ext         = {1'b0, rob_used};
        flags.congested = (miss_sum >= MISS_ON) || (rob_ext >= ROB_ON);
        flags.cleared   = (miss_sum < MISS_OFF) && (rob_ext < ROB_OFF);
    end

endmodule

// File: rtl/smt_thr_fsm.sv
module smt_thr_fsm
    import smt_thr_pkg::*;
#(
    parameter int ROB_W     = 6,
    parameter int INH_DLY   = 8,
    parameter int FLUSH_DLY = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  cong_flags_t [NTHR-1:0]     flags,
    input  logic [NTHR-1:0][ROB_W-1:0] rob_used,
    output logic [NTHR-1:0]            lowered,
    output logic [NTHR-1:0]            inhibit,
    output logic [NTHR-1:0]            flush
);
    localparam int MAX_DLY = (INH_DLY > FLUSH_DLY) ? INH_DLY : FLUSH_DLY;
    localparam int CNT_W   = $clog2(MAX_DLY + 1);

    thr_state_e       st_q, st_d;
    logic             vic_q, vic_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             any_cong;

    assign any_cong = flags[0].congested || flags[1].congested;

    always_comb begin
        st_d  = st_q;
        vic_d = vic_q;
        cnt_d = cnt_q;
        case (st_q)
            TS_IDLE: begin
                if (any_cong) begin
                    st_d  = TS_LOWER;
                    cnt_d = '0;
                    if (flags[0].congested && flags[1].congested)
                        vic_d = (rob_used[1] > rob_used[0]);
                    else
                        vic_d = flags[1].congested;
                end
            end
            TS_LOWER: begin
                if (cnt_q == CNT_W'(INH_DLY - 1)) begin
                    st_d  = TS_INHIBIT;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            TS_INHIBIT: begin
                if (cnt_q == CNT_W'(FLUSH_DLY - 1)) begin
                    st_d  = TS_FLUSH;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            TS_FLUSH: st_d = TS_BLOCK;
            TS_BLOCK: st_d = TS_BLOCK;
            default:  st_d = TS_IDLE;
        endcase
        // Release wins over any escalation step in the same cycle.
        if (st_q != TS_IDLE && flags[vic_q].cleared) begin
            st_d  = TS_IDLE;
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= TS_IDLE;
            vic_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            vic_q <= vic_d;
            cnt_q <= cnt_d;
        end
    end

    for (genvar t = 0; t < NTHR; t++) begin : g_out
        logic mine;
        assign mine       = (vic_q == 1'(t));
        assign lowered[t] = mine && (st_q == TS_LOWER);
        assign inhibit[t] = mine && (st_q == TS_INHIBIT || st_q == TS_FLUSH ||
                                     st_q == TS_BLOCK);
        assign flush[t]   = mine && (st_q == TS_FLUSH);
    end

    // R4: a congested thread is demoted in the following cycle
    a_r4_enter_lower: assert property (@(posedge clk) disable iff (rst)
        (st_q == TS_IDLE && any_cong) |=> (|lowered));

    // R5: inhibit only ever follows the lowered stage
    a_r5_inhibit_after_lower: assert property (@(posedge clk) disable iff (rst)
        $rose(|inhibit) |-> $past(|lowered));

    // R6: the flush request lasts a single cycle
    a_r6_flush_single: assert property (@(posedge clk) disable iff (rst)
        (|flush) |=> !(|flush));

    // R7: release in the cycle after the victim clears
    a_r7_release: assert property (@(posedge clk) disable iff (rst)
        ((|(lowered | inhibit)) && flags[vic_q].cleared) |=> !(|(lowered | inhibit)));

    // R8: never more than one thread under throttle
    a_r8_one_victim: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lowered | inhibit));

endmodule

// File: rtl/smt_thr_decode_alloc.sv
module smt_thr_decode_alloc
    import smt_thr_pkg::*;
#(
    parameter int PRIO_W = 3,
    parameter int WINDOW = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NTHR-1:0][PRIO_W-1:0] prio,
    input  logic [NTHR-1:0]             lowered,
    input  logic [NTHR-1:0]             inhibit,
    output logic [NTHR-1:0]             grant
);
    localparam int POS_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;

    logic [POS_W-1:0]  pos_q;
    int unsigned       weight [NTHR];
    int unsigned       split;
    int unsigned       pos_u;

    always_ff @(posedge clk) begin
        if (rst)                               pos_q <= '0;
        else if (pos_q == POS_W'(WINDOW - 1))  pos_q <= '0;
        else                                   pos_q <= pos_q + POS_W'(1);
    end

    for (genvar t = 0; t < NTHR; t++) begin : g_weight
        always_comb begin
            if (inhibit[t])      weight[t] = 0;
            else if (lowered[t]) weight[t] = demote(32'(prio[t]));
            else                 weight[t] = 32'(prio[t]);
        end
    end

    always_comb begin
        pos_u    = 32'(pos_q);
        split    = first_share(weight[0], weight[1], WINDOW);
        grant[0] = (weight[0] != 0) && (pos_u < split);
        grant[1] = (weight[1] != 0) && (pos_u >= split);
    end

    // R2: the window wraps to position 0
    a_r2_window_wrap: assert property (@(posedge clk) disable iff (rst)
        (pos_q == POS_W'(WINDOW - 1)) |=> (pos_q == '0));

    // R3: zero priority on an unthrottled thread yields no slot
    a_r3_zero_prio: assert property (@(posedge clk) disable iff (rst)
        (prio[0] == '0 && !lowered[0]) |-> !grant[0]);

    // R9: one decode slot per cycle
    a_r9_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

endmodule

// File: rtl/smt_thr_throttle.sv
module smt_thr_throttle
    import smt_thr_pkg::*;
#(
    parameter int PRIO_W    = 3,
    parameter int MISS_W    = 5,
    parameter int ROB_W     = 6,
    parameter int MISS_TH   = 8,
    parameter int ROB_TH    = 40,
    parameter int HYST      = 4,
    parameter int WINDOW    = 8,
    parameter int INH_DLY   = 8,
    parameter int FLUSH_DLY = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NTHR-1:0][PRIO_W-1:0]  prio_i,
    input  logic [NTHR-1:0][MISS_W-1:0]  l2_miss_i,
    input  logic [NTHR-1:0][MISS_W-1:0]  tlb_miss_i,
    input  logic [NTHR-1:0][ROB_W-1:0]   rob_used_i,
    output logic [NTHR-1:0]              decode_grant_o,
    output logic [NTHR-1:0]              decode_inhibit_o,
    output logic [NTHR-1:0]              dispatch_flush_o
);
    cong_flags_t [NTHR-1:0] flags;
    logic [NTHR-1:0]        lowered;
    logic [NTHR-1:0]        inhibit;

    for (genvar t = 0; t < NTHR; t++) begin : g_mon
        smt_thr_cong_mon #(
            .MISS_W (MISS_W),
            .ROB_W  (ROB_W),
            .MISS_TH(MISS_TH),
            .ROB_TH (ROB_TH),
            .HYST   (HYST)
        ) u_mon (
            .l2_miss (l2_miss_i[t]),
            .tlb_miss(tlb_miss_i[t]),
            .rob_used(rob_used_i[t]),
            .flags   (flags[t])
        );
    end

    smt_thr_fsm #(
        .ROB_W    (ROB_W),
        .INH_DLY  (INH_DLY),
        .FLUSH_DLY(FLUSH_DLY)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .flags   (flags),
        .rob_used(rob_used_i),
        .lowered (lowered),
        .inhibit (inhibit),
        .flush   (dispatch_flush_o)
    );

    smt_thr_decode_alloc #(
        .PRIO_W(PRIO_W),
        .WINDOW(WINDOW)
    ) u_alloc (
        .clk    (clk),
        .rst    (rst),
        .prio   (prio_i),
        .lowered(lowered),
        .inhibit(inhibit),
        .grant  (decode_grant_o)
    );

    assign decode_inhibit_o = inhibit;

    // R9: an inhibited thread never holds the decode slot
    a_r9_no_grant_inhibited: assert property (@(posedge clk) disable iff (rst)
        (decode_grant_o & decode_inhibit_o) == '0);

endmodule

// File: tb/smt_thr_throttle_bench.sv
module smt_thr_throttle_bench;

    localparam int MISS_TH = 8;
    localparam int ROB_TH  = 40;
    localparam int HYST    = 4;
    localparam int WINDOW  = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0][2:0]  prio;
    logic [1:0][4:0]  l2m;
    logic [1:0][4:0]  tlbm;
    logic [1:0][5:0]  rob;
    logic [1:0]       grant, inh, fl;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    // reference model state
    int m_st = 0;   // 0 idle, 1 lowered, 2 inhibit, 3 flush, 4 blocked
    int m_vic = 0;
    int m_cnt = 0;
    int m_pos = 0;

    always #10 clk = ~clk;

    smt_thr_throttle u_smt_thr_throttle (
        .clk             (clk),
        .rst             (rst),
        .prio_i          (prio),
        .l2_miss_i       (l2m),
        .tlb_miss_i      (tlbm),
        .rob_used_i      (rob),
        .decode_grant_o  (grant),
        .decode_inhibit_o(inh),
        .dispatch_flush_o(fl)
    );

    function automatic bit is_cong(int t);
        return (int'(l2m[t]) + int'(tlbm[t]) >= MISS_TH) || (int'(rob[t]) >= ROB_TH);
    endfunction

    function automatic bit is_clear(int t);
        return (int'(l2m[t]) + int'(tlbm[t]) < MISS_TH - HYST) && (int'(rob[t]) < ROB_TH - HYST);
    endfunction

    task automatic model_advance();
        int nst, nvic, ncnt;
        if (rst) begin
            m_st = 0; m_vic = 0; m_cnt = 0; m_pos = 0;
            return;
        end
        nst = m_st; nvic = m_vic; ncnt = m_cnt;
        if (m_st == 0) begin
            if (is_cong(0) || is_cong(1)) begin
                nst = 1; ncnt = 0;
                if (is_cong(0) && is_cong(1)) nvic = (rob[1] > rob[0]) ? 1 : 0;
                else nvic = is_cong(1) ? 1 : 0;
            end
        end else if (m_st == 1) begin
            if (m_cnt == 7) begin nst = 2; ncnt = 0; end else ncnt = m_cnt + 1;
        end else if (m_st == 2) begin
            if (m_cnt == 31) begin nst = 3; ncnt = 0; end else ncnt = m_cnt + 1;
        end else if (m_st == 3) begin
            nst = 4;
        end
        if (m_st != 0 && is_clear(m_vic)) begin nst = 0; ncnt = 0; end
        m_st = nst; m_vic = nvic; m_cnt = ncnt;
        m_pos = (m_pos + 1) % WINDOW;
    endtask

    task automatic check(string t, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b (state %0d pos %0d)", t, act, exp, m_st, m_pos);
        end
    endtask

    task automatic compare();
        int w [2];
        int s0;
        logic [1:0] eg, ei, ef;
        for (int t = 0; t < 2; t++) begin
            if (m_st >= 2 && m_vic == t) w[t] = 0;
            else if (m_st == 1 && m_vic == t) w[t] = (prio[t] > 1) ? int'(prio[t]) - 1 : int'(prio[t]);
            else w[t] = int'(prio[t]);
        end
        if (w[0] + w[1] == 0) s0 = 0;
        else if (w[1] == 0) s0 = WINDOW;
        else s0 = (w[0] * WINDOW) / (w[0] + w[1]);
        eg[0] = (w[0] != 0) && (m_pos < s0);
        eg[1] = (w[1] != 0) && (m_pos >= s0);
        ei = 2'b00; ef = 2'b00;
        if (m_st >= 2) ei[m_vic] = 1'b1;
        if (m_st == 3) ef[m_vic] = 1'b1;
        check(tag, grant, eg);
        check("R5 inhibit", inh, ei);
        check("R6 flush", fl, ef);
        check("R9 single grant", {1'b0, ($countones(grant) <= 1) && ((grant & inh) == 2'b00)}, 2'b01);
    endtask

    task automatic step();
        @(posedge clk);
        model_advance();
        @(negedge clk);
        compare();
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic set_thr(int t, int p, int l2, int tl, int r);
        prio[t] = 3'(p); l2m[t] = 5'(l2); tlbm[t] = 5'(tl); rob[t] = 6'(r);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #4_000_000;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        set_thr(0, 4, 0, 0, 0);
        set_thr(1, 4, 0, 0, 0);
        // R1: reset state
        tag = "R1";
        run(3);
        @(negedge clk);
        rst = 1'b0;
        step();
        check("R1 first grant", grant, 2'b01);
        check("R1 no inhibit", inh, 2'b00);
        // R2: uneven split 6:2 then 1:7
        tag = "R2";
        set_thr(0, 6, 0, 0, 0); set_thr(1, 2, 0, 0, 0);
        run(16);
        set_thr(0, 1, 0, 0, 0); set_thr(1, 7, 0, 0, 0);
        run(16);
        // R3: zero priority
        tag = "R3";
        set_thr(0, 0, 0, 0, 0); set_thr(1, 5, 0, 0, 0);
        run(12);
        set_thr(1, 0, 0, 0, 0);
        run(10);
        // R4/R5/R6: thread 1 miss-sum congestion at exactly the threshold
        tag = "R4";
        set_thr(0, 2, 0, 0, 0); set_thr(1, 2, 5, 3, 10);
        run(9);
        tag = "R5";
        run(32);
        tag = "R6";
        run(12);
        // R7: hover in the hysteresis band, then drop below release
        tag = "R7";
        set_thr(1, 2, 2, 2, 36);
        run(10);
        set_thr(1, 2, 1, 2, 35);
        run(10);
        // R8: both congested, larger reorder count wins; then a tie
        tag = "R8";
        set_thr(0, 3, 0, 0, 45); set_thr(1, 3, 0, 0, 50);
        run(12);
        set_thr(0, 3, 0, 0, 0); set_thr(1, 3, 0, 0, 0);
        run(3);
        set_thr(0, 3, 0, 0, 44); set_thr(1, 3, 0, 0, 44);
        run(12);
        set_thr(0, 3, 0, 0, 0); set_thr(1, 3, 0, 0, 0);
        run(3);
        // R2 with random held values spanning trigger and release levels
        tag = "R2";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 30) == 0) begin
                int t;
                t = int'($urandom_range(0, 1));
                set_thr(t, int'($urandom_range(0, 7)), int'($urandom_range(0, 6)),
                        int'($urandom_range(0, 5)), int'($urandom_range(20, 52)));
            end
            step();
        end
        finish_run();
    end

endmodule